// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block is a 32-bit general-purpose I/O port that sits on a simple single-cycle memory-mapped bus. Software sets each pin's direction, then drives it through an output latch. It can load the whole latch at once through a pin-value register, or change single bits through set and clear registers. A per-bit mask register selects which pins any of these paths may touch. Masked bits are left alone on writes and read as zero. The pin-value register can also be reached through a byte window and a half-word window, so software can update one lane of the port without a read-modify-write.

Reads are combinational. `bus_rdata` reflects the addressed register in the same cycle that `bus_sel` is high with `bus_wr` low. Writes take effect at the next rising clock edge. Pin inputs pass through a synchroniser before they can be read back. For a pin configured as an output, the read-back value is the latch bit instead of the input.

Register offsets (byte addresses):

- 0x00: direction register.
- 0x04: mask register.
- 0x08: full-word pin value.
- 0x0C: set register.
- 0x10: clear register.
- 0x14 to 0x17: byte window.
- 0x18 and 0x1A: half-word window.

Size codes on `bus_size`: 0 is a byte, 1 is a half-word, 2 is a word, and 3 is reserved.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the output latch, direction register and mask register are all zero, so `pin_out` and `pin_oe` are 0x00000000.
- R2: A word write to offset 0x08 loads `bus_wdata[i]` into latch bit i for every i whose mask bit is 0. Latch bits whose mask bit is 1 keep their value.
- R3: A read of the pin value returns 0 in each bit whose mask bit is 1. Each other bit returns the latch bit if its direction bit is 1, and the synchronised input if its direction bit is 0.
- R4: A change on `pin_in` of an input pin appears in the pin-value read after exactly two rising clock edges, not after one.
- R5: Offsets 0x00 to 0x10 accept word-size accesses only. An access there with any other size changes no state and reads as 0.
- R6: A byte-size access at 0x14+k (k = 0 to 3) works like the pin-value register on lane k only. Data travels on `bus_wdata`/`bus_rdata` bits 8k+7:8k. Other lanes keep their latch values and read as 0.
- R7: A half-word access at 0x18 uses bits 15:0, and one at 0x1A uses bits 31:16, with the same masked behaviour. Other bits are untouched and read as 0.
- R8: A word write to 0x0C sets every latch bit where the data bit is 1 and the mask bit is 0. All other latch bits are unchanged.
- R9: A word write to 0x10 clears every latch bit where the data bit is 1 and the mask bit is 0. All other latch bits are unchanged.
- R10: Word writes to 0x00 and 0x04 load the direction and mask registers, and word reads return them. `pin_oe` equals the direction register. `pin_out` equals the latch, and a read of 0x0C or 0x10 returns the latch.
- R11: Accesses to unmapped offsets, a reserved size, a size that does not match the window, or an odd half-word offset are ignored: no state change, and the read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, lane-aligned |
| bus_rdata | output | 32 | Read data, combinational, lane-aligned |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable per pin |

## Verification
The hardest case to reach is a read that mixes all three sources at once. In such a read some bits are masked, some come from the latch because their pins are outputs, and the rest come from freshly synchronised inputs. On top of that, the access is a byte or half-word alias that must pick only its own lanes. The stimulus first writes random direction and mask words. It then changes `pin_in` and lets the synchroniser settle. Finally it issues random-size accesses over both the valid windows and the illegal offsets. Directed steps cover the two-edge synchroniser latency, masked set and clear, and misaligned or wrongly sized alias accesses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int OFF_DIR  = 'h00;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_PIN  = 'h08;
  localparam int OFF_SET  = 'h0C;
  localparam int OFF_CLR  = 'h10;
  localparam int OFF_BYTE = 'h14;
  localparam int OFF_HALF = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_MASK,
    SEL_PIN,
    SEL_SET,
    SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                 sel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output reg_sel_e             rsel,
  output logic [WIDTH/8-1:0]   lane_en
);
  localparam int LANES = WIDTH / 8;

  logic word_acc;
  logic byte_hit;
  logic half_hit;

  always_comb begin
    word_acc = sel && (size == SZ_WORD);
    byte_hit = sel && (size == SZ_BYTE) &&
               (addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_BYTE >> 2));
    half_hit = sel && (size == SZ_HALF) && !addr[0] &&
               (addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_HALF >> 2));
  end

  always_comb begin
    rsel = SEL_NONE;
    if (word_acc) begin
      if      (addr == ADDR_W'(OFF_DIR))  rsel = SEL_DIR;
      else if (addr == ADDR_W'(OFF_MASK)) rsel = SEL_MASK;
      else if (addr == ADDR_W'(OFF_PIN))  rsel = SEL_PIN;
      else if (addr == ADDR_W'(OFF_SET))  rsel = SEL_SET;
      else if (addr == ADDR_W'(OFF_CLR))  rsel = SEL_CLR;
    end else if (byte_hit || half_hit) begin
      rsel = SEL_PIN;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lane_en[l] = word_acc ||
                   (byte_hit && (addr[1:0] == 2'(l))) ||
                   (half_hit && (addr[1] == 1'(l / 2)));
    end
  end
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         rsel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q
);
  logic dir_en;
  logic mask_en;

  always_comb begin
    dir_en  = wr_en && (rsel == SEL_DIR);
    mask_en = wr_en && (rsel == SEL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_port_latch.sv
module gpio_port_latch
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         rsel,
  input  logic [WIDTH-1:0] bit_en,
  input  logic [WIDTH-1:0] mask_q,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] wr_ok;
  logic [WIDTH-1:0] latch_d;
  logic             latch_en;

  always_comb begin
    wr_ok    = bit_en & ~mask_q;
    latch_en = 1'b0;
    latch_d  = latch_q;
    if (wr_en) begin
      unique case (rsel)
        SEL_PIN: begin
          latch_en = 1'b1;
          latch_d  = (latch_q & ~wr_ok) | (wdata & wr_ok);
        end
        SEL_SET: begin
          latch_en = 1'b1;
          latch_d  = latch_q | (wdata & wr_ok);
        end
        SEL_CLR: begin
          latch_en = 1'b1;
          latch_d  = latch_q & ~(wdata & wr_ok);
        end
        default: begin
          latch_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam int LANES = WIDTH / 8;

  reg_sel_e         rsel;
  logic [LANES-1:0] lane_en;
  logic [WIDTH-1:0] bit_en;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] pin_view;
  logic             wr_en;
  logic             rd_en;

  gpio_port_decode #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_decode (
    .sel     (bus_sel),
    .addr    (bus_addr),
    .size    (bus_size),
    .rsel    (rsel),
    .lane_en (lane_en)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit_en
    assign bit_en[b] = lane_en[b / 8];
  end

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  gpio_port_cfg #(.WIDTH(WIDTH)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rsel   (rsel),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .mask_q (mask_q)
  );

  gpio_port_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rsel    (rsel),
    .bit_en  (bit_en),
    .mask_q  (mask_q),
    .wdata   (bus_wdata),
    .latch_q (latch_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  always_comb begin
    pin_view  = (dir_q & latch_q) | (~dir_q & sync_q);
    bus_rdata = '0;
    if (rd_en) begin
      unique case (rsel)
        SEL_DIR:          bus_rdata = dir_q;
        SEL_MASK:         bus_rdata = mask_q;
        SEL_PIN:          bus_rdata = pin_view & ~mask_q & bit_en;
        SEL_SET, SEL_CLR: bus_rdata = latch_q;
        default:          bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  mask_q
);
  logic wr_cyc;
  logic rd_pin_word;
  logic wr_set;
  logic wr_clr;
  logic wr_dir;
  logic wr_pin_bad;

  assign wr_cyc      = bus_sel && bus_wr;
  assign rd_pin_word = bus_sel && !bus_wr && bus_addr == ADDR_W'('h08) && bus_size == 2'd2;
  assign wr_set      = wr_cyc && bus_addr == ADDR_W'('h0C) && bus_size == 2'd2;
  assign wr_clr      = wr_cyc && bus_addr == ADDR_W'('h10) && bus_size == 2'd2;
  assign wr_dir      = wr_cyc && bus_addr == ADDR_W'('h00) && bus_size == 2'd2;
  assign wr_pin_bad  = wr_cyc && bus_addr == ADDR_W'('h08) && bus_size != 2'd2;

  AST_MASKED_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0)); // R2

  AST_LATCH_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |=> $stable(pin_out)); // R2

  AST_MASKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pin_word |-> ((bus_rdata & mask_q) == '0)); // R3

  AST_BAD_SIZE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin_bad |=> $stable(pin_out)); // R5

  AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (($past(pin_out) & ~pin_out) == '0)); // R8

  AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((~$past(pin_out) & pin_out) == '0)); // R9

  AST_OE_ONLY_ON_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe)); // R10
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mask_q    (mask_q)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks;
  int failures;
  bit done;

  logic [31:0] m_dir, m_mask, m_lat, m_pin;

  gpio_mask_port u_gpio_mask_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int kind_of(logic [4:0] a, logic [1:0] sz);
    if (sz == 2'd2) begin
      case (a)
        5'h00: return 1;
        5'h04: return 2;
        5'h08: return 3;
        5'h0C: return 4;
        5'h10: return 5;
        default: return 0;
      endcase
    end
    if (sz == 2'd0 && a >= 5'h14 && a <= 5'h17) return 3;
    if (sz == 2'd1 && (a == 5'h18 || a == 5'h1A)) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] ben_of(logic [4:0] a, logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF << (8 * (a - 5'h14));
    if (sz == 2'd1) return 32'hFFFF << (16 * ((a - 5'h18) / 2));
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a, logic [1:0] sz);
    case (kind_of(a, sz))
      1: return m_dir;
      2: return m_mask;
      3: return ((m_dir & m_lat) | (~m_dir & m_pin)) & ~m_mask & ben_of(a, sz);
      4, 5: return m_lat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(logic [4:0] a, logic [1:0] sz, logic [31:0] d);
    logic [31:0] en;
    en = ben_of(a, sz) & ~m_mask;
    case (kind_of(a, sz))
      1: m_dir  = d;
      2: m_mask = d;
      3: m_lat  = (m_lat & ~en) | (d & en);
      4: m_lat  = m_lat | (d & en);
      5: m_lat  = m_lat & ~(d & en);
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [1:0] sz, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(a, sz, d);
  endtask

  task automatic do_read(logic [4:0] a, logic [1:0] sz, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz; bus_wdata = '0;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic read_check(string tag, logic [4:0] a, logic [1:0] sz);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_read(a, sz);
    do_read(a, sz, d);
    check(tag, d, e);
  endtask

  task automatic set_pins(logic [31:0] v);
    pin_in = v;
    repeat (3) @(negedge clk);
    m_pin = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    checks = 0; failures = 0; done = 1'b0;
    void'($urandom(32'd20240611));
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
    pin_in = 32'h0;
    m_dir = 0; m_mask = 0; m_lat = 0; m_pin = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    read_check("R1 mask", 5'h04, 2'd2);

    // R4: two-edge synchroniser latency on input pins
    set_pins(32'hA5A5_0F0F);
    pin_in = 32'h5A5A_F0F0;
    do_read(5'h08, 2'd2, d); check("R4 zero edges", d, 32'hA5A5_0F0F);
    do_read(5'h08, 2'd2, d); check("R4 one edge", d, 32'hA5A5_0F0F);
    do_read(5'h08, 2'd2, d); check("R4 two edges", d, 32'h5A5A_F0F0);
    m_pin = 32'h5A5A_F0F0;

    // R10: direction and mask registers
    do_write(5'h00, 2'd2, 32'hFFFF_FFFF);
    check("R10 pin_oe", pin_oe, 32'hFFFF_FFFF);
    do_write(5'h04, 2'd2, 32'hFF00_00F0);
    read_check("R10 mask read", 5'h04, 2'd2);

    // R2: masked full-word write
    do_write(5'h08, 2'd2, 32'h1234_5678);
    check("R2 masked word write", pin_out, 32'h0034_5608);
    read_check("R3 masked read", 5'h08, 2'd2);

    // R5: wrong size on the word register
    do_write(5'h08, 2'd0, 32'hFFFF_FFFF);
    check("R5 byte write ignored", pin_out, 32'h0034_5608);
    read_check("R5 half read zero", 5'h08, 2'd1);

    // R6: byte window, lane 2 unmasked, lane 3 masked
    do_write(5'h04, 2'd2, 32'hFF00_0000);
    do_write(5'h16, 2'd0, 32'h00AB_0000);
    check("R6 byte lane 2", pin_out, 32'h00AB_5608);
    do_write(5'h17, 2'd0, 32'hFF00_0000);
    check("R6 masked lane 3", pin_out, 32'h00AB_5608);
    read_check("R6 byte read", 5'h15, 2'd0);

    // R7: half-word window
    do_write(5'h04, 2'd2, 32'h0000_0000);
    do_write(5'h1A, 2'd1, 32'hBEEF_0000);
    check("R7 upper half", pin_out, 32'hBEEF_5608);
    read_check("R7 lower read", 5'h18, 2'd1);

    // R11: misaligned half and reserved size
    do_write(5'h19, 2'd1, 32'hFFFF_FFFF);
    do_write(5'h08, 2'd3, 32'hFFFF_FFFF);
    do_write(5'h1C, 2'd2, 32'hFFFF_FFFF);
    check("R11 ignored writes", pin_out, 32'hBEEF_5608);
    read_check("R11 odd half read", 5'h19, 2'd1);

    // R8 / R9: set and clear under a mask
    do_write(5'h04, 2'd2, 32'h0000_FFFF);
    do_write(5'h0C, 2'd2, 32'hFFFF_FFFF);
    check("R8 masked set", pin_out, 32'hFFFF_5608);
    do_write(5'h10, 2'd2, 32'h0F0F_0F0F);
    check("R9 masked clear", pin_out, 32'hF0F0_5608);
    read_check("R10 set read latch", 5'h0C, 2'd2);

    // Mixed random traffic: R2 R3 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < 800; i++) begin
      logic [4:0]  a;
      logic [1:0]  sz;
      logic [31:0] dv;
      if (i % 100 == 0) set_pins($urandom);
      if ($urandom % 2) begin
        case ($urandom % 9)
          0: begin a = 5'h00; sz = 2'd2; end
          1: begin a = 5'h04; sz = 2'd2; end
          2: begin a = 5'h08; sz = 2'd2; end
          3: begin a = 5'h0C; sz = 2'd2; end
          4: begin a = 5'h10; sz = 2'd2; end
          5, 6: begin a = 5'(5'h14 + ($urandom % 4)); sz = 2'd0; end
          default: begin a = 5'(5'h18 + 2 * ($urandom % 2)); sz = 2'd1; end
        endcase
      end else begin
        a  = 5'($urandom);
        sz = 2'($urandom);
      end
      dv = $urandom;
      if ($urandom % 2) begin
        do_write(a, sz, dv);
        check("R2 random latch", pin_out, m_lat);
        check("R10 random oe", pin_oe, m_dir);
      end else begin
        read_check("R3 random read", a, sz);
      end
    end

    finish_run();
  end
endmodule